// File: doc/BRIEF.md
# Multi-Channel I/O Base Decoder

This block sits on a 16-bit ISA I/O address and decides which of up to three identical peripheral channels owns the current cycle. Each channel is given a 10-bit base setting. A channel claims a 32-byte window that starts at that base and is aligned to a 32-byte boundary. The block compares each setting with the middle address bits and qualifies the result with the I/O read and write strobes. It then raises at most one channel enable and passes the low five address bits through as a register offset for the selected channel.

Channels may be left unfitted, and two or more channels may be set to the same base by mistake. A per-channel present input removes a missing channel from the decode. Any remaining collision is settled by a fixed priority: the highest-numbered channel wins. The whole path is combinational, so the enables follow the address and strobes within the same bus cycle.

Top module: `ioBaseDecoder`

## Requirements
- R1: With both `iorStb` and `iowStb` low, every bit of `chanEn` is low, whatever the address and settings.
- R2: Channel k (bit k of `chanEn`, setting in `chanBase[10k+9:10k]`) is enabled when a strobe is high, `ioAddr[14:5]` equals its setting, `ioAddr[15]` is 0, it is present, and no higher-numbered channel qualifies.
- R3: When `ioAddr[15]` is 1, no channel is enabled.
- R4: A channel matches for all 32 addresses of its window: any value of `ioAddr[4:0]` gives the same decision. An address one window above or below gives no match for that channel.
- R5: When several qualifying channels share one base, only the highest bit index of `chanEn` is set; bit 2 beats bit 1, and bit 1 beats bit 0.
- R6: At no time is more than one bit of `chanEn` high.
- R7: A channel whose `chanPresent` bit is 0 is never enabled, and the next lower qualifying channel takes its place.
- R8: `regOffset` always equals `ioAddr[4:0]`, whether or not any channel is enabled.
- R9: A read strobe alone, a write strobe alone, or both together each qualify the decode in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ioAddr | input | 16 | I/O address from the bus |
| iorStb | input | 1 | I/O read strobe, active high |
| iowStb | input | 1 | I/O write strobe, active high |
| chanBase | input | 30 | Packed base settings, 10 bits per channel, channel 0 in the low bits |
| chanPresent | input | 3 | Per-channel fitted flag |
| chanEn | output | 3 | One-hot-or-zero channel enables |
| regOffset | output | 5 | Register offset within the 32-byte window |

## Verification
The in-RTL checks assume that all inputs are settled, known values when they are evaluated. Each check is therefore skipped while any input carries X or Z, which covers the time before the bench drives anything. The bench meets this assumption by always driving complete, known values. It changes inputs on the falling clock edge and samples two nanoseconds later. The random part draws base settings from a small pool so that collisions are frequent. It aims most addresses at one of the configured bases, so that matches, priority contests and masked channels occur far more often than pure random addresses would give.

// File: rtl/ioBaseDecPkg.sv
package ioBaseDecPkg;
  localparam int NUM_CHAN = 3;
  localparam int ADDR_W   = 16;
  localparam int BASE_W   = 10;
  localparam int WIN_W    = 5;
  localparam int HIGH_W   = ADDR_W - BASE_W - WIN_W;

  // Strobes the datapath hands to the control
  typedef struct packed {
    logic [NUM_CHAN-1:0] baseHit;   // per-channel base compare result
    logic                highClear; // address bits above the compare field are all zero
  } decStrobes_t;
endpackage

// File: rtl/ioBaseDecDatapath.sv
module ioBaseDecDatapath
  import ioBaseDecPkg::*;
#(
  parameter int NUM_CH = NUM_CHAN,
  parameter int AW     = ADDR_W,
  parameter int BW     = BASE_W,
  parameter int WW     = WIN_W
) (
  input  logic [AW-1:0]        ioAddr,
  input  logic [NUM_CH*BW-1:0] chanBase,
  output decStrobes_t          decStb,
  output logic [WW-1:0]        regOffset
);
  localparam int FIELD_LO = WW;
  localparam int FIELD_HI = WW + BW - 1;
  localparam int HW       = AW - BW - WW;

  logic [BW-1:0] addrField;
  assign addrField = ioAddr[FIELD_HI:FIELD_LO];
  assign regOffset = ioAddr[WW-1:0];

  // One comparator per channel
  for (genvar c = 0; c < NUM_CH; c++) begin : gCmp
    assign decStb.baseHit[c] = (addrField == chanBase[c*BW +: BW]);
  end

  // Upper-bit qualification, present only if the address is wider than the field
  if (HW > 0) begin : gHigh
    assign decStb.highClear = ~|ioAddr[AW-1:FIELD_HI+1];
  end else begin : gNoHigh
    assign decStb.highClear = 1'b1;
  end
endmodule

// File: rtl/ioBaseDecControl.sv
module ioBaseDecControl
  import ioBaseDecPkg::*;
#(
  parameter int NUM_CH = NUM_CHAN
) (
  input  decStrobes_t       decStb,
  input  logic              iorStb,
  input  logic              iowStb,
  input  logic [NUM_CH-1:0] chanPresent,
  output logic [NUM_CH-1:0] chanEn
);
  logic              accessOn;
  logic [NUM_CH-1:0] candidate;

  assign accessOn  = iorStb | iowStb;
  assign candidate = decStb.baseHit & chanPresent & {NUM_CH{accessOn & decStb.highClear}};

  // Fixed priority: highest index first
  always_comb begin
    logic taken;
    taken  = 1'b0;
    chanEn = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      chanEn[i] = candidate[i] & ~taken;
      taken     = taken | candidate[i];
    end
  end

  always_comb begin
    if (!$isunknown({decStb, iorStb, iowStb, chanPresent, chanEn})) begin
      assert_one_enable_R6: assert ($onehot0(chanEn))
        else $error("more than one channel enabled");
      assert_strobe_needed_R1: assert ((chanEn == '0) || iorStb || iowStb)
        else $error("enable without strobe");
      assert_present_mask_R7: assert ((chanEn & ~chanPresent) == '0)
        else $error("absent channel enabled");
      assert_hit_needed_R2: assert ((chanEn & ~decStb.baseHit) == '0)
        else $error("enable without base hit");
    end
  end
endmodule

// File: rtl/ioBaseDecoder.sv
module ioBaseDecoder
  import ioBaseDecPkg::*;
(
  input  logic [ADDR_W-1:0]          ioAddr,
  input  logic                       iorStb,
  input  logic                       iowStb,
  input  logic [NUM_CHAN*BASE_W-1:0] chanBase,
  input  logic [NUM_CHAN-1:0]        chanPresent,
  output logic [NUM_CHAN-1:0]        chanEn,
  output logic [WIN_W-1:0]           regOffset
);
  decStrobes_t decStb;

  ioBaseDecDatapath #(
    .NUM_CH(NUM_CHAN), .AW(ADDR_W), .BW(BASE_W), .WW(WIN_W)
  ) datapath_i (
    .ioAddr   (ioAddr),
    .chanBase (chanBase),
    .decStb   (decStb),
    .regOffset(regOffset)
  );

  ioBaseDecControl #(
    .NUM_CH(NUM_CHAN)
  ) control_i (
    .decStb     (decStb),
    .iorStb     (iorStb),
    .iowStb     (iowStb),
    .chanPresent(chanPresent),
    .chanEn     (chanEn)
  );

  always_comb begin
    if (!$isunknown({ioAddr, chanEn})) begin
      assert_high_bit_blocks_R3: assert (!ioAddr[ADDR_W-1] || (chanEn == '0))
        else $error("enable with top address bit set");
    end
  end
endmodule

// File: tb/ioBaseDecoder_tb.sv
module ioBaseDecoder_tb_top;
  logic        clk = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        iorStb = 1'b0;
  logic        iowStb = 1'b0;
  logic [29:0] chanBase = '0;
  logic [2:0]  chanPresent = 3'b111;
  logic [2:0]  chanEn;
  logic [4:0]  regOffset;
  int          nRun = 0;
  int          nFail = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  ioBaseDecoder dut_i (
    .ioAddr(ioAddr), .iorStb(iorStb), .iowStb(iowStb),
    .chanBase(chanBase), .chanPresent(chanPresent),
    .chanEn(chanEn), .regOffset(regOffset)
  );

  function automatic logic [2:0] expEn(logic [15:0] a, logic r, logic w,
                                       logic [29:0] b, logic [2:0] p);
    logic [2:0] e = '0;
    if ((r || w) && !a[15]) begin
      for (int k = 2; k >= 0; k--) begin
        if (p[k] && (a[14:5] == b[k*10 +: 10])) begin
          e[k] = 1'b1;
          break;
        end
      end
    end
    return e;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] a, logic r, logic w, logic [29:0] b,
                       logic [2:0] p, string req);
    @(negedge clk);
    ioAddr = a; iorStb = r; iowStb = w; chanBase = b; chanPresent = p;
    #2;
    check(req, {5'd0, chanEn}, {5'd0, expEn(a, r, w, b, p)});
    check("R8", {3'd0, regOffset}, {3'd0, a[4:0]});
    check("R6", {7'd0, ($countones(chanEn) > 1)}, 8'd0);
  endtask

  function automatic logic [29:0] bases(logic [9:0] b2, logic [9:0] b1, logic [9:0] b0);
    return {b2, b1, b0};
  endfunction

  initial begin
    logic [29:0] bs;
    logic [9:0]  pool [4];
    void'($urandom(32'd1234));
    #2;
    // idle state
    check("R1", {5'd0, chanEn}, 8'd0);
    bs = bases(10'h030, 10'h020, 10'h010);
    apply({1'b0, 10'h010, 5'd0}, 0, 0, bs, 3'b111, "R1");
    apply({1'b0, 10'h010, 5'd0}, 1, 0, bs, 3'b111, "R2");
    apply({1'b0, 10'h020, 5'd7}, 0, 1, bs, 3'b111, "R9");
    apply({1'b0, 10'h030, 5'd3}, 1, 1, bs, 3'b111, "R9");
    apply({1'b1, 10'h010, 5'd0}, 1, 0, bs, 3'b111, "R3");
    apply({1'b0, 10'h010, 5'd31}, 1, 0, bs, 3'b111, "R4");
    apply({1'b0, 10'h011, 5'd0}, 1, 0, bs, 3'b111, "R4");
    apply({1'b0, 10'h00F, 5'd31}, 1, 0, bs, 3'b111, "R4");
    bs = bases(10'h155, 10'h155, 10'h155);
    apply({1'b0, 10'h155, 5'd4}, 1, 0, bs, 3'b111, "R5");
    check("R5", {5'd0, chanEn}, 8'h04);
    apply({1'b0, 10'h155, 5'd4}, 0, 1, bs, 3'b011, "R7");
    check("R7", {5'd0, chanEn}, 8'h02);
    apply({1'b0, 10'h155, 5'd4}, 0, 1, bs, 3'b001, "R7");
    check("R7", {5'd0, chanEn}, 8'h01);
    apply({1'b0, 10'h155, 5'd4}, 1, 0, bs, 3'b000, "R7");
    check("R7", {5'd0, chanEn}, 8'h00);
    // random with frequent collisions
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      for (int k = 0; k < 4; k++) pool[k] = 10'($urandom_range(0, 1023));
      bs = bases(pool[$urandom_range(0, 3)], pool[$urandom_range(0, 3)],
                 pool[$urandom_range(0, 3)]);
      a = 16'($urandom);
      if ($urandom_range(0, 3) != 0) a[14:5] = bs[$urandom_range(0, 2)*10 +: 10];
      if ($urandom_range(0, 3) != 0) a[15] = 1'b0;
      apply(a, 1'($urandom), 1'($urandom), bs, 3'($urandom), "R2");
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule